// File: doc/BRIEF.md
# Page-Mode Burst Read Sequencer

This block drives an asynchronous 16-bit static RAM to read a run of consecutive words from a single internal page of the memory. The memory treats the upper twelve address bits as a page selector and the lower four bits as a word index within that page. While the page bits stay the same and chip enable stays active, the memory stays in its reduced-current page mode. The sequencer keeps the page bits fixed and chip enable asserted for the whole burst, and steps only the word index.

A client pulses `start` with a page number, a starting word offset and a requested word count. Each word address is held for `ACC_CYCLES` clock cycles, which must cover the memory's address-access time (70 ns or 55 ns, depending on speed grade). On the last cycle of that hold the returned data is captured and presented with a one-cycle `out_valid` pulse, and the word index then advances. A request that would run past word 15 is cut short at the page end. A `done` pulse reports how many words were actually delivered. After each burst the memory is released and one idle cycle passes before a new start is accepted.

Top module: `pbr_burst_reader`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `sram_ce_n`, `sram_oe_n`, `sram_ub_n`, `sram_lb_n` and `sram_we_n` are all 1, and `out_valid` and `done` are 0.
- R2: `sram_addr[15:4]` carries the page latched at the accepted start, `sram_addr[3:0]` carries the word index, and `sram_addr[15:4]` does not change in any cycle in which `sram_ce_n` was 0 in both that cycle and the previous one.
- R3: `sram_we_n` is always 1. During a burst, `sram_ce_n`, `sram_oe_n`, `sram_ub_n` and `sram_lb_n` are all 0, so every word returns all 16 bits.
- R4: Suppose a start is accepted at clock edge E. The first word address appears right after E. Each word address is held for exactly `ACC_CYCLES` cycles. The word is captured at the last edge of that hold, and `out_valid` is 1 for the one cycle that follows. At that same edge the word index increments by one.
- R5: The number of words delivered is min(`word_cnt`, 16 − `word_off`), where `word_cnt` is 5 bits wide (0 to 31).
- R6: `done` is a one-cycle pulse. `done_count` equals the number of words delivered. For a nonzero count, `done` coincides with the last `out_valid`. For a zero count, `done` is raised in the cycle after the start, and `sram_ce_n` never falls.
- R7: `sram_ce_n` and `sram_oe_n` return to 1 in the same cycle as `done`. A `start` presented in that cycle is ignored. A `start` presented in the following cycle is accepted.
- R8: A `start` pulse arriving while a burst is in progress is ignored. The running burst keeps its page, its word sequence and its count.
- R9: The word on `out_data` at the k-th `out_valid` of a burst (k counted from 0) is the memory word at address {page, `word_off` + k}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse; sampled only while idle |
| page_addr | input | 12 | Page to read from |
| word_off | input | 4 | First word index in the page |
| word_cnt | input | 5 | Requested number of words |
| sram_addr | output | 16 | Memory address: page in bits 15:4, word in bits 3:0 |
| sram_ce_n | output | 1 | Memory chip enable, active low |
| sram_oe_n | output | 1 | Memory output enable, active low |
| sram_we_n | output | 1 | Memory write enable, held high |
| sram_ub_n | output | 1 | Upper byte select, active low |
| sram_lb_n | output | 1 | Lower byte select, active low |
| sram_dq_in | input | 16 | Data returned by the memory |
| out_valid | output | 1 | One-cycle flag for a delivered word |
| out_data | output | 16 | Delivered word |
| done | output | 1 | One-cycle end-of-burst flag |
| done_count | output | 5 | Words delivered in the finished burst |

## Verification
The hardest situations to reach from the ports are a `start` arriving in the middle of a running burst and a `start` arriving in exactly the single cycle where `done` is raised. A well-behaved client would never produce either one. The stimulus therefore injects these pulses on purpose during a sweep over every offset and every count from 0 to 17 on several pages. For each burst it then checks cycle by cycle that the chip enable, the page bits and the word order are unaffected. The memory model returns a distinct value per address and marks disabled byte lanes, so wrong addresses, wrong capture cycles and byte-select errors all show up on `out_data`.

// File: rtl/pbr_pkg.sv
package pbr_pkg;

    localparam int PAGE_BITS      = 12;
    localparam int WORD_BITS      = 4;
    localparam int DATA_BITS      = 16;
    localparam int ADDR_BITS      = PAGE_BITS + WORD_BITS;
    localparam int WORDS_PER_PAGE = 1 << WORD_BITS;
    localparam int CNT_BITS       = WORD_BITS + 1;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCESS = 2'd1,
        ST_GAP    = 2'd2
    } seq_state_t;

    typedef struct packed {
        logic [PAGE_BITS-1:0] page;
        logic [WORD_BITS-1:0] word;
    } mem_addr_t;

    // Words that can actually be read from the offset to the end of the page.
    function automatic logic [CNT_BITS-1:0] clip_count(
        input logic [WORD_BITS-1:0] off,
        input logic [CNT_BITS-1:0]  req
    );
        logic [CNT_BITS-1:0] room;
        room = CNT_BITS'(WORDS_PER_PAGE) - {1'b0, off};
        return (req < room) ? req : room;
    endfunction

endpackage

// File: rtl/pbr_access_timer.sv
module pbr_access_timer #(
    parameter int ACC_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic run,
    output logic last
);
    localparam int TMR_W = (ACC_CYCLES > 2) ? $clog2(ACC_CYCLES) : 1;
    localparam logic [TMR_W-1:0] TMR_MAX = TMR_W'(ACC_CYCLES - 1);

    logic [TMR_W-1:0] tmr;

    assign last = run && (tmr == TMR_MAX);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            tmr <= '0;
        end else if (run) begin
            tmr <= (tmr == TMR_MAX) ? '0 : tmr + TMR_W'(1);
        end
    end

    // R4: hold counter never leaves its window
    a_r4_timer_range: assert property (@(posedge clk) disable iff (rst)
        tmr <= TMR_MAX);

endmodule

// File: rtl/pbr_word_walker.sv
module pbr_word_walker
    import pbr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic [WORD_BITS-1:0] off,
    input  logic [CNT_BITS-1:0]  count,
    input  logic                 step,
    output logic [WORD_BITS-1:0] word,
    output logic                 last_word,
    output logic [CNT_BITS-1:0]  delivered
);
    logic [CNT_BITS-1:0] remain;

    assign last_word = (remain == CNT_BITS'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            word      <= '0;
            remain    <= '0;
            delivered <= '0;
        end else if (load) begin
            word      <= off;
            remain    <= count;
            delivered <= '0;
        end else if (step) begin
            if (!last_word) begin
                word <= word + WORD_BITS'(1);
            end
            remain    <= remain - CNT_BITS'(1);
            delivered <= delivered + CNT_BITS'(1);
        end
    end

    // R5: never more words than a page holds
    a_r5_delivered_bound: assert property (@(posedge clk) disable iff (rst)
        (delivered + remain) <= CNT_BITS'(WORDS_PER_PAGE));

endmodule

// File: rtl/pbr_capture.sv
module pbr_capture
    import pbr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 take,
    input  logic [DATA_BITS-1:0] din,
    output logic                 valid,
    output logic [DATA_BITS-1:0] dout
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            dout  <= '0;
        end else begin
            valid <= take;
            if (take) begin
                dout <= din;
            end
        end
    end

    // R4: a delivered word is flagged for a single cycle
    a_r4_valid_pulse: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);

endmodule

// File: rtl/pbr_burst_reader.sv
module pbr_burst_reader
    import pbr_pkg::*;
#(
    parameter int ACC_CYCLES = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [PAGE_BITS-1:0] page_addr,
    input  logic [WORD_BITS-1:0] word_off,
    input  logic [CNT_BITS-1:0]  word_cnt,
    output logic [ADDR_BITS-1:0] sram_addr,
    output logic                 sram_ce_n,
    output logic                 sram_oe_n,
    output logic                 sram_we_n,
    output logic                 sram_ub_n,
    output logic                 sram_lb_n,
    input  logic [DATA_BITS-1:0] sram_dq_in,
    output logic                 out_valid,
    output logic [DATA_BITS-1:0] out_data,
    output logic                 done,
    output logic [CNT_BITS-1:0]  done_count
);
    seq_state_t           state;
    logic                 enable_n;
    logic [PAGE_BITS-1:0] page_q;
    logic [CNT_BITS-1:0]  eff_cnt;
    logic                 accept;
    logic                 hold_last;
    logic                 capture;
    logic [WORD_BITS-1:0] word;
    logic                 last_word;
    logic [CNT_BITS-1:0]  delivered;
    mem_addr_t            addr_s;

    assign eff_cnt = clip_count(word_off, word_cnt);
    assign accept  = (state == ST_IDLE) && start;
    assign capture = (state == ST_ACCESS) && hold_last;

    pbr_access_timer #(.ACC_CYCLES(ACC_CYCLES)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .restart (accept),
        .run     (state == ST_ACCESS),
        .last    (hold_last)
    );

    pbr_word_walker u_walk (
        .clk       (clk),
        .rst       (rst),
        .load      (accept && (eff_cnt != '0)),
        .off       (word_off),
        .count     (eff_cnt),
        .step      (capture),
        .word      (word),
        .last_word (last_word),
        .delivered (delivered)
    );

    pbr_capture u_cap (
        .clk   (clk),
        .rst   (rst),
        .take  (capture),
        .din   (sram_dq_in),
        .valid (out_valid),
        .dout  (out_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            enable_n   <= 1'b1;
            page_q     <= '0;
            done       <= 1'b0;
            done_count <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        page_q <= page_addr;
                        if (eff_cnt == '0) begin
                            done       <= 1'b1;
                            done_count <= '0;
                            state      <= ST_GAP;
                        end else begin
                            enable_n <= 1'b0;
                            state    <= ST_ACCESS;
                        end
                    end
                end
                ST_ACCESS: begin
                    if (hold_last && last_word) begin
                        enable_n   <= 1'b1;
                        done       <= 1'b1;
                        done_count <= delivered + CNT_BITS'(1);
                        state      <= ST_GAP;
                    end
                end
                ST_GAP: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign addr_s.page = page_q;
    assign addr_s.word = word;
    assign sram_addr   = addr_s;
    assign sram_ce_n   = enable_n;
    assign sram_oe_n   = enable_n;
    assign sram_ub_n   = enable_n;
    assign sram_lb_n   = enable_n;
    assign sram_we_n   = 1'b1;

    // R2: page bits frozen while the memory stays enabled
    a_r2_page_hold: assert property (@(posedge clk) disable iff (rst)
        (!sram_ce_n && $past(!sram_ce_n)) |->
            sram_addr[ADDR_BITS-1:WORD_BITS] == $past(sram_addr[ADDR_BITS-1:WORD_BITS]));

    // R4: inside a burst the word index only moves up by one
    a_r4_word_step: assert property (@(posedge clk) disable iff (rst)
        (!sram_ce_n && $past(!sram_ce_n) &&
         sram_addr[WORD_BITS-1:0] != $past(sram_addr[WORD_BITS-1:0])) |->
            sram_addr[WORD_BITS-1:0] == WORD_BITS'($past(sram_addr[WORD_BITS-1:0]) + 1));

    // R6: nonzero completion coincides with the final word
    a_r6_done_with_last: assert property (@(posedge clk) disable iff (rst)
        (done && done_count != '0) |-> out_valid);

    // R6: reported count fits in a page
    a_r6_count_range: assert property (@(posedge clk) disable iff (rst)
        done |-> done_count <= CNT_BITS'(WORDS_PER_PAGE));

    // R7: memory released for at least one cycle after a burst
    a_r7_gap_after_end: assert property (@(posedge clk) disable iff (rst)
        $rose(sram_ce_n) |=> sram_ce_n);

    // R4: data is only delivered from an enabled memory
    a_r4_valid_from_enabled: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(!sram_ce_n));

endmodule

// File: tb/sim_pbr_burst_reader.sv
`timescale 1ns/1ps
module sim_pbr_burst_reader;
    localparam int CLK_PERIOD = 20;
    localparam int ACC = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [11:0] page_addr = '0;
    logic [3:0]  word_off = '0;
    logic [4:0]  word_cnt = '0;
    logic [15:0] sram_addr;
    logic        sram_ce_n, sram_oe_n, sram_we_n, sram_ub_n, sram_lb_n;
    logic [15:0] sram_dq_in;
    logic        out_valid;
    logic [15:0] out_data;
    logic        done;
    logic [4:0]  done_count;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] pat(input logic [15:0] a);
        return (a * 16'h9E37) ^ 16'h5A5A;
    endfunction

    logic [15:0] mem_word;
    assign mem_word   = pat(sram_addr);
    assign sram_dq_in = (!sram_ce_n && !sram_oe_n) ?
                        {sram_ub_n ? 8'hEE : mem_word[15:8],
                         sram_lb_n ? 8'hEE : mem_word[7:0]} : 16'hEEEE;

    pbr_burst_reader #(.ACC_CYCLES(ACC)) u0 (
        .clk(clk), .rst(rst), .start(start), .page_addr(page_addr),
        .word_off(word_off), .word_cnt(word_cnt), .sram_addr(sram_addr),
        .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n),
        .sram_ub_n(sram_ub_n), .sram_lb_n(sram_lb_n), .sram_dq_in(sram_dq_in),
        .out_valid(out_valid), .out_data(out_data), .done(done),
        .done_count(done_count)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_idle_pins(input string req);
        chk(sram_ce_n == 1'b1, req, sram_ce_n, 1);
        chk(sram_oe_n == 1'b1, req, sram_oe_n, 1);
        chk(sram_we_n == 1'b1, req, sram_we_n, 1);
    endtask

    // Called at a negedge with the design idle.
    task automatic run_burst(input logic [11:0] pg, input int off, input int cnt,
                             input bit poke_busy, input bit poke_gap);
        int n;
        int last_k;
        n = (cnt < 16 - off) ? cnt : 16 - off;   // R5
        last_k = n * ACC;
        page_addr = pg;
        word_off  = 4'(off);
        word_cnt  = 5'(cnt);
        start     = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k <= last_k; k++) begin
            if (k < last_k) begin
                // R3: enables low, WE high during the burst
                chk(!sram_ce_n && !sram_oe_n && !sram_ub_n && !sram_lb_n,
                    "R3", {sram_ce_n, sram_oe_n, sram_ub_n, sram_lb_n}, 0);
                chk(sram_we_n == 1'b1, "R3", sram_we_n, 1);
                // R2: page bits fixed
                chk(sram_addr[15:4] == pg, "R2", sram_addr[15:4], pg);
                // R4: word index held ACC cycles and stepping by one
                chk(sram_addr[3:0] == 4'(off + k / ACC), "R4",
                    sram_addr[3:0], off + k / ACC);
                chk(out_valid == (k > 0 && k % ACC == 0), "R4", out_valid,
                    (k > 0 && k % ACC == 0));
                chk(done == 1'b0, "R6", done, 0);
                if (k > 0 && k % ACC == 0)
                    chk(out_data == pat({pg, 4'(off + k / ACC - 1)}), "R9",
                        out_data, pat({pg, 4'(off + k / ACC - 1)}));
            end else begin
                chk(done == 1'b1, "R6", done, 1);
                chk(done_count == 5'(n), "R5", done_count, n);
                chk_idle_pins("R7");
                if (n > 0) begin
                    chk(out_valid == 1'b1, "R6", out_valid, 1);
                    chk(out_data == pat({pg, 4'(off + n - 1)}), "R9",
                        out_data, pat({pg, 4'(off + n - 1)}));
                end else begin
                    chk(out_valid == 1'b0, "R6", out_valid, 0);
                end
            end
            // R8: a start inside the burst must be ignored
            if (poke_busy && n >= 2 && k == ACC + 1) begin
                page_addr = ~pg;
                word_off  = 4'd0;
                word_cnt  = 5'd16;
                start     = 1'b1;
            end else if (poke_gap && k == last_k) begin
                page_addr = ~pg;
                word_off  = 4'd1;
                word_cnt  = 5'd3;
                start     = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        // Idle cycle after the done cycle
        chk(done == 1'b0, "R6", done, 0);
        chk(out_valid == 1'b0, "R7", out_valid, 0);
        chk_idle_pins(poke_gap ? "R7" : "R6");
        if (poke_gap) begin
            @(negedge clk);
            chk(sram_ce_n == 1'b1, "R7", sram_ce_n, 1);
            chk(done == 1'b0, "R7", done, 0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [11:0] pages [3];
        pages[0] = 12'h000;
        pages[1] = 12'hFFF;
        pages[2] = 12'hA5C;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk_idle_pins("R1");
        chk(sram_ub_n && sram_lb_n, "R1", {sram_ub_n, sram_lb_n}, 3);
        chk(out_valid == 1'b0 && done == 1'b0, "R1", {out_valid, done}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk_idle_pins("R1");
        chk(out_valid == 1'b0 && done == 1'b0, "R1", {out_valid, done}, 0);
        for (int p = 0; p < 3; p++) begin
            for (int off = 0; off < 16; off++) begin
                for (int cnt = 0; cnt < 18; cnt++) begin
                    run_burst(pages[p], off, cnt,
                              ((off + cnt) % 3) == 0, (cnt % 4) == 1);
                end
            end
        end
        // Back-to-back: a start in the first idle cycle is accepted (R7)
        run_burst(12'h123, 14, 5, 1'b0, 1'b0);
        run_burst(12'h124, 0, 1, 1'b0, 1'b0);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule